// File: doc/BRIEF.md
# Power-Good Strap Capture and Output Sequencer

This block sits next to the clock generator's pin logic. It records two frequency-select strap levels exactly once, on the first clock in which the active-low power-good strobe is seen low. Every later move on the strobe or the straps is ignored. Once the straps are recorded, the two dual-purpose pins stop being inputs and become reference clock outputs. The recorded straps are also exported so that a register block can read them back.

The block decodes the recorded strap pair together with a register override bit. The result is either normal operation with a CPU frequency code, or one of two test modes: divided-reference or all outputs high-impedance. In normal operation a counter of slow ticks runs after capture, and outputs are enabled only when that count expires. After test mode is entered, the second strap no longer matters. The first strap, read live and without a register, then chooses between the two test modes. The only way out of test mode is reset.

Top module: `strap_seq_top`

## Requirements
- R1: After reset, mode is NORMAL (2'b00), freq_code is 0, pins_are_out is 0, out_en is 0 and latched_straps is 2'b00.
- R2: The straps are captured on the first rising clock edge at which pwrgd_n is 0. latched_straps holds {strap_a, strap_b} from that edge. pins_are_out goes to 1 on the cycle after that edge.
- R3: After capture, no change on pwrgd_n, strap_a or strap_b alters latched_straps or pins_are_out until reset.
- R4: With fast_sel=0, latched {a,b}=00 gives freq_code 0 (100 MHz), 01 gives 2 (200 MHz) and 10 gives 1 (133 MHz).
- R5: With fast_sel=1, latched {a,b}=00 gives freq_code 2 (200 MHz), 01 gives 4 (400 MHz) and 10 gives 3 (266 MHz). fast_sel is read live.
- R6: Latched {a,b}=11 enters test mode.
- R7: In test mode, mode equals TEST_REF (2'b01) when the live strap_a is 0 and TEST_HIZ (2'b10) when it is 1. The mode output follows strap_a combinationally, and strap_b has no effect.
- R8: In normal mode, out_en rises exactly DELAY_TICKS tick pulses after capture and stays 1. In test mode, out_en stays 0.
- R9: Only reset leaves test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, stands for a power cycle |
| pwrgd_n | input | 1 | Active-low power-good strobe |
| strap_a | input | 1 | First frequency strap pin level |
| strap_b | input | 1 | Second frequency strap pin level |
| fast_sel | input | 1 | Register override that selects the doubled frequency table |
| tick | input | 1 | Slow timebase pulse, one clock wide |
| freq_code | output | 3 | Index of the selected CPU frequency |
| mode | output | 2 | 00 normal, 01 divided reference, 10 high-impedance |
| pins_are_out | output | 1 | 1 once the strap pins drive reference clocks |
| out_en | output | 1 | Clock outputs enabled |
| latched_straps | output | 2 | Captured {strap_a, strap_b} |

## Verification
The bench sweeps all strap pairs under both override settings, and it moves the straps after capture. A design that re-sampled the straps on a second low strobe would report the new strap values. The bench also pulses the strobe high and low again after capture, so a design that treated each falling edge as a capture would change its frequency. In test mode, toggling strap_a must flip the mode with no clock edge, and a registered decode would lag by one cycle. Toggling strap_b in test mode must change nothing. The enable delay is counted tick by tick: an off-by-one counter would enable outputs one tick early or one tick late, and this is caught at both ends of the window.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_DELAY = 2'd1,
        ST_RUN   = 2'd2,
        ST_TEST  = 2'd3
    } seq_state_e;

    localparam logic [1:0] MODE_NORMAL   = 2'b00;
    localparam logic [1:0] MODE_TEST_REF = 2'b01;
    localparam logic [1:0] MODE_TEST_HIZ = 2'b10;

    localparam logic [2:0] FREQ_100 = 3'd0;
    localparam logic [2:0] FREQ_133 = 3'd1;
    localparam logic [2:0] FREQ_200 = 3'd2;
    localparam logic [2:0] FREQ_266 = 3'd3;
    localparam logic [2:0] FREQ_400 = 3'd4;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import strap_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwrgd_n,
    input  logic       strap_a,
    input  logic       strap_b,
    output logic       captured,
    output logic [1:0] straps
);
    typedef struct packed {
        logic       done;
        logic [1:0] val;
    } cap_t;

    cap_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.done && !pwrgd_n) begin
            s_d.done = 1'b1;
            s_d.val  = {strap_a, strap_b};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign captured = s_q.done;
    assign straps   = s_q.val;
endmodule

// File: rtl/strap_decode.sv
module strap_decode
    import strap_seq_pkg::*;
(
    input  logic [1:0] straps,
    input  logic       fast_sel,
    output logic       is_test,
    output logic [2:0] freq_code
);
    always_comb begin
        is_test   = 1'b0;
        freq_code = FREQ_100;
        unique case (straps)
            2'b00: freq_code = fast_sel ? FREQ_200 : FREQ_100;
            2'b01: freq_code = fast_sel ? FREQ_400 : FREQ_200;
            2'b10: freq_code = fast_sel ? FREQ_266 : FREQ_133;
            default: is_test = 1'b1;
        endcase
    end
endmodule

// File: rtl/enable_timer.sv
module enable_timer #(
    parameter int DELAY_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(DELAY_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DELAY_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fin;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start && !t_q.fin && tick) begin
            t_d.cnt = t_q.cnt + 1'b1;
            if (t_q.cnt + 1'b1 == LIMIT) t_d.fin = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expired = t_q.fin;
endmodule

// File: rtl/strap_seq_top.sv
module strap_seq_top
    import strap_seq_pkg::*;
#(
    parameter int DELAY_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwrgd_n,
    input  logic       strap_a,
    input  logic       strap_b,
    input  logic       fast_sel,
    input  logic       tick,
    output logic [2:0] freq_code,
    output logic [1:0] mode,
    output logic       pins_are_out,
    output logic       out_en,
    output logic [1:0] latched_straps
);
    logic       captured, is_test, expired;
    logic [1:0] straps;
    logic [2:0] dec_freq;

    typedef struct packed {
        seq_state_e st;
        logic       en;
    } seq_t;

    seq_t q_d, q_q;

    strap_capture u_cap (
        .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n),
        .strap_a(strap_a), .strap_b(strap_b),
        .captured(captured), .straps(straps)
    );

    strap_decode u_dec (
        .straps(straps), .fast_sel(fast_sel),
        .is_test(is_test), .freq_code(dec_freq)
    );

    enable_timer #(.DELAY_TICKS(DELAY_TICKS)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .start(q_q.st == ST_DELAY), .tick(tick),
        .expired(expired)
    );

    always_comb begin
        q_d = q_q;
        unique case (q_q.st)
            ST_WAIT:  if (captured) q_d.st = is_test ? ST_TEST : ST_DELAY;
            ST_DELAY: if (expired) begin
                q_d.st = ST_RUN;
                q_d.en = 1'b1;
            end
            ST_RUN:   q_d.en = 1'b1;
            ST_TEST:  q_d.en = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{st: ST_WAIT, en: 1'b0};
        else        q_q <= q_d;
    end

    wire in_test = captured && is_test;

    assign mode           = in_test ? (strap_a ? MODE_TEST_HIZ : MODE_TEST_REF) : MODE_NORMAL;
    assign freq_code      = (captured && !is_test) ? dec_freq : FREQ_100;
    assign pins_are_out   = captured;
    assign out_en         = q_q.en;
    assign latched_straps = straps;
endmodule

// File: rtl/strap_seq_chk.sv
module strap_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwrgd_n,
    input logic       strap_a,
    input logic       strap_b,
    input logic [1:0] mode,
    input logic       pins_are_out,
    input logic       out_en,
    input logic [1:0] latched_straps
);
    AST_CAPTURE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!pins_are_out && !pwrgd_n) |=> (pins_are_out && latched_straps == $past({strap_a, strap_b}))); // R2
    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        pins_are_out |=> (pins_are_out && $stable(latched_straps))); // R3
    AST_TEST_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00) |-> !out_en); // R8
    AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |=> out_en); // R8
    AST_TEST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00) |=> (mode != 2'b00)); // R9
    AST_NO_EN_BEFORE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_are_out |-> !out_en); // R1
endmodule

bind strap_seq_top strap_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .strap_a(strap_a),
    .strap_b(strap_b), .mode(mode), .pins_are_out(pins_are_out),
    .out_en(out_en), .latched_straps(latched_straps)
);

// File: tb/sim_strap_seq_top.sv
module sim_strap_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int DELAY = 4;

    logic clk = 0, rst_n = 0, pwrgd_n = 1, strap_a = 0, strap_b = 0, fast_sel = 0, tick = 0;
    logic [2:0] freq_code;
    logic [1:0] mode, latched_straps;
    logic pins_are_out, out_en;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_seq_top #(.DELAY_TICKS(DELAY)) u0 (
        .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .strap_a(strap_a),
        .strap_b(strap_b), .fast_sel(fast_sel), .tick(tick),
        .freq_code(freq_code), .mode(mode), .pins_are_out(pins_are_out),
        .out_en(out_en), .latched_straps(latched_straps)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick = 1; step(1); tick = 0; step(1);
    endtask

    task automatic do_reset();
        rst_n = 0; pwrgd_n = 1; tick = 0; step(2); rst_n = 1; step(1);
    endtask

    function automatic int exp_freq(input bit a, input bit b, input bit f);
        int base;
        base = (!a && !b) ? 0 : (!a && b) ? 2 : 1;
        return f ? base + 2 : base;
    endfunction

    initial begin
        do_reset();
        chk("R1 mode", mode, 0);
        chk("R1 freq", freq_code, 0);
        chk("R1 pins", pins_are_out, 0);
        chk("R1 en", out_en, 0);
        chk("R1 latch", latched_straps, 0);

        for (int s = 0; s < 3; s++) begin
            for (int f = 0; f < 2; f++) begin
                do_reset();
                strap_a = s[1]; strap_b = s[0]; fast_sel = f[0];
                step(2);
                chk("R2 not yet captured", pins_are_out, 0);
                pwrgd_n = 0; step(1);
                chk("R2 pins out", pins_are_out, 1);
                chk("R2 latch", latched_straps, s);
                chk(f ? "R5 freq" : "R4 freq", freq_code, exp_freq(s[1], s[0], f[0]));
                strap_a = ~strap_a; strap_b = ~strap_b;
                pwrgd_n = 1; step(1); pwrgd_n = 0; step(1);
                chk("R3 latch held", latched_straps, s);
                chk("R3 freq held", freq_code, exp_freq(s[1], s[0], f[0]));
                chk("R6 normal mode", mode, 0);
                for (int t = 0; t < DELAY - 1; t++) pulse_tick();
                chk("R8 not early", out_en, 0);
                pulse_tick();
                chk("R8 enabled", out_en, 1);
                step(5);
                chk("R8 stays", out_en, 1);
                fast_sel = ~fast_sel; #1;
                chk("R5 live override", freq_code, exp_freq(s[1], s[0], ~f[0]));
            end
        end

        do_reset();
        strap_a = 1; strap_b = 1; pwrgd_n = 0; step(1);
        chk("R6 test entered", mode, 2);
        strap_a = 0; #1;
        chk("R7 async ref", mode, 1);
        strap_b = 0; #1;
        chk("R7 strap_b ignored", mode, 1);
        strap_a = 1; #1;
        chk("R7 async hiz", mode, 2);
        for (int t = 0; t < DELAY + 2; t++) pulse_tick();
        chk("R8 test no enable", out_en, 0);
        pwrgd_n = 1; step(2); pwrgd_n = 0; step(2);
        chk("R9 still test", mode, 2);
        chk("R9 latch", latched_straps, 3);
        do_reset();
        chk("R9 reset leaves test", mode, 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule